// File: doc/BRIEF.md
# Fully Associative Branch Target Cache

This block sits in the fetch stage of a pipelined processor. It keeps a small set of taken branches. For each one it holds the branch's word address and the target the branch most recently jumped to. In every cycle the current fetch address is compared against all stored branch addresses at once. A match is read as a taken prediction, and the stored target is offered as the next fetch address in that same cycle. With no match, fetch moves on to the sequential word.

When a branch resolves, the execute stage reports the branch address, the resolved target and whether the branch was taken. The outcome decides what happens to the stored entries:

- A taken branch that is not stored takes the slot named by a round-robin pointer.
- A taken branch that is already stored has its target refreshed in place.
- A not-taken branch that is stored is removed, because the presence of an entry is itself the taken prediction.

Top module: `brtgt_cache`

## Requirements
- R1: After reset every entry is invalid, so no fetch address produces a hit.
- R2: When the fetch address matches a valid entry, pred_hit is 1 and both pred_target and next_fetch_addr equal that entry's stored target. This is combinational and appears in the same cycle the fetch address is presented.
- R3: When there is no match, pred_hit is 0 and next_fetch_addr is fetch_addr + 4, wrapping modulo 2^32.
- R4: A taken update (upd_valid=1, upd_taken=1) whose address matches no valid entry writes the address and target into one slot at the rising edge. It hits from the next cycle on, and no two valid entries ever hold the same address.
- R5: With the default depth, 64 distinct taken branches are all held at once, and each one hits with its own target.
- R6: After reset, allocation starts at slot 0 and steps through the slots in order, wrapping around. The allocation that follows 64 earlier allocations therefore evicts the oldest allocated branch and leaves the others in place.
- R7: A not-taken update (upd_taken=0) whose address matches a valid entry invalidates that entry. Other entries are unaffected.
- R8: A taken update that matches a valid entry replaces its target and does not advance the allocation pointer.
- R9: When an update and a lookup address the same entry in one cycle, the lookup returns the contents held before that update.
- R10: Addresses are compared on bits 31:2 only. Bits 1:0 of fetch_addr and of upd_pc are ignored in both lookup and update.
- R11: An update presented with upd_valid=0, or a not-taken update that matches no entry, changes no entry and does not move the allocation pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | 32 | Current fetch address |
| pred_hit | output | 1 | Fetch address matched a stored taken branch |
| pred_target | output | 32 | Stored target of the matching entry (0 on a miss) |
| next_fetch_addr | output | 32 | Predicted target on a hit, fetch_addr + 4 otherwise |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target of the branch |
| upd_taken | input | 1 | 1 if the branch was taken |

## Verification
Several properties are checked on every cycle:

- At most one entry matches a lookup.
- A hit redirects to the reported target, and a miss falls through to the sequential address.
- An allocation advances the round-robin pointer by one with wrap-around, and every other kind of update leaves it still.
- An allocated slot becomes valid, and an invalidated slot goes invalid.
- Reset leaves every slot empty.

Some behaviours can only be shown by the bench's scenarios. These are the eviction order across a full wrap of the 64 slots, the fact that refreshing a target does not disturb that order, the old-contents view when an update and a lookup collide in one cycle, and the masking of the two low address bits.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned TAG_W  = ADDR_W - 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TAG_W-1:0]  tag_t;

  // word address: low two byte-offset bits are not part of the tag
  function automatic tag_t word_tag(input addr_t a);
    return a[ADDR_W-1:2];
  endfunction

  // sequential fetch address, one 4-byte word ahead
  function automatic addr_t seq_fetch(input addr_t a);
    return a + addr_t'(4);
  endfunction
endpackage

// File: rtl/brtgt_slot.sv
module brtgt_slot
  import brtgt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  do_alloc,
  input  logic  do_retarget,
  input  logic  do_inval,
  input  tag_t  wr_tag,
  input  addr_t wr_target,
  input  tag_t  look_tag,
  input  tag_t  upd_tag,
  output logic  valid,
  output logic  look_match,
  output logic  upd_match,
  output addr_t target
);
  tag_t tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      tag_q  <= '0;
      target <= '0;
    end else if (do_alloc) begin
      valid  <= 1'b1;
      tag_q  <= wr_tag;
      target <= wr_target;
    end else if (do_retarget) begin
      target <= wr_target;
    end else if (do_inval) begin
      valid  <= 1'b0;
    end
  end

  assign look_match = valid && (tag_q == look_tag);
  assign upd_match  = valid && (tag_q == upd_tag);
endmodule

// File: rtl/brtgt_victim.sv
module brtgt_victim #(
  parameter int unsigned ENTRIES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] ptr
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= next_slot(ptr);
  end
endmodule

// File: rtl/brtgt_hit_sel.sv
module brtgt_hit_sel
  import brtgt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic [ENTRIES-1:0]         look_vec,
  input  logic [ENTRIES-1:0]         upd_vec,
  input  addr_t [ENTRIES-1:0]        tgt_arr,
  output addr_t                      look_target,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] upd_idx
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // AND-OR select; at most one bit of vec is set
  function automatic addr_t pick_target(input logic [ENTRIES-1:0] vec,
                                        input addr_t [ENTRIES-1:0] arr);
    addr_t acc = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vec[i]) acc = acc | arr[i];
    return acc;
  endfunction

  function automatic logic [IDX_W-1:0] encode(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vec[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  assign look_target = pick_target(look_vec, tgt_arr);
  assign upd_idx     = encode(upd_vec);
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
  import brtgt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] next_fetch_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tag_t look_tag;
  tag_t upd_tag;
  assign look_tag = word_tag(fetch_addr);
  assign upd_tag  = word_tag(upd_pc);

  // per-slot status, brought out for the checker
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] look_hit_vec;
  logic [ENTRIES-1:0] upd_hit_vec;
  addr_t [ENTRIES-1:0] tgt_arr;

  logic             upd_hit_any;
  logic [IDX_W-1:0] upd_idx;
  logic [IDX_W-1:0] alloc_ptr;
  logic             alloc_evt;
  logic             retarget_evt;
  logic             inval_evt;

  assign upd_hit_any  = |upd_hit_vec;
  assign alloc_evt    = upd_valid &&  upd_taken && !upd_hit_any;
  assign retarget_evt = upd_valid &&  upd_taken &&  upd_hit_any;
  assign inval_evt    = upd_valid && !upd_taken &&  upd_hit_any;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel_alloc, sel_retarget, sel_inval;
    assign sel_alloc    = alloc_evt && (alloc_ptr == IDX_W'(g));
    assign sel_retarget = retarget_evt && upd_hit_vec[g];
    assign sel_inval    = inval_evt && upd_hit_vec[g];

    brtgt_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .do_alloc    (sel_alloc),
      .do_retarget (sel_retarget),
      .do_inval    (sel_inval),
      .wr_tag      (upd_tag),
      .wr_target   (upd_target),
      .look_tag    (look_tag),
      .upd_tag     (upd_tag),
      .valid       (valid_vec[g]),
      .look_match  (look_hit_vec[g]),
      .upd_match   (upd_hit_vec[g]),
      .target      (tgt_arr[g])
    );
  end

  brtgt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (alloc_evt),
    .ptr     (alloc_ptr)
  );

  addr_t hit_target;
  brtgt_hit_sel #(.ENTRIES(ENTRIES)) u_sel (
    .look_vec    (look_hit_vec),
    .upd_vec     (upd_hit_vec),
    .tgt_arr     (tgt_arr),
    .look_target (hit_target),
    .upd_idx     (upd_idx)
  );

  assign pred_hit        = |look_hit_vec;
  assign pred_target     = hit_target;
  assign next_fetch_addr = pred_hit ? hit_target : seq_fetch(fetch_addr);
endmodule

// File: rtl/brtgt_cache_chk.sv
module brtgt_cache_chk
  import brtgt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_target,
  input logic [ADDR_W-1:0] next_fetch_addr,
  input logic              upd_valid,
  input logic [ENTRIES-1:0] look_hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] alloc_ptr,
  input logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] upd_idx,
  input logic              alloc_evt,
  input logic              inval_evt
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_vec == '0));

  p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hit_vec));

  p_hit_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> (next_fetch_addr == pred_target));

  p_miss_sequential_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (next_fetch_addr == fetch_addr + 32'd4));

  p_alloc_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |=> valid_vec[$past(alloc_ptr)]);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |=> (alloc_ptr == (($past(alloc_ptr) == LAST) ? '0 : $past(alloc_ptr) + 1'b1)));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !alloc_evt) |=> $stable(alloc_ptr));

  p_ptr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(alloc_ptr));

  p_inval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inval_evt |=> !valid_vec[$past(upd_idx)]);
endmodule

bind brtgt_cache brtgt_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fetch_addr      (fetch_addr),
  .pred_hit        (pred_hit),
  .pred_target     (pred_target),
  .next_fetch_addr (next_fetch_addr),
  .upd_valid       (upd_valid),
  .look_hit_vec    (look_hit_vec),
  .valid_vec       (valid_vec),
  .alloc_ptr       (alloc_ptr),
  .upd_idx         (upd_idx),
  .alloc_evt       (alloc_evt),
  .inval_evt       (inval_evt)
);

// File: tb/brtgt_cache_bench.sv
module brtgt_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic [31:0] next_fetch_addr;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  brtgt_cache u_brtgt_cache (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .pred_hit(pred_hit),
    .pred_target(pred_target), .next_fetch_addr(next_fetch_addr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken)
  );

  function automatic logic [31:0] br_pc(input int i);
    return 32'h0000_1000 + 32'(i) * 32'd16;
  endfunction
  function automatic logic [31:0] br_tgt(input int i);
    return 32'h0008_0000 + 32'(i) * 32'd4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // present a fetch address and check the same-cycle prediction
  task automatic look(input logic [31:0] a, input bit exp_hit,
                      input logic [31:0] exp_tgt, input string req);
    logic [31:0] exp_next;
    fetch_addr = a;
    #1;
    exp_next = exp_hit ? exp_tgt : a + 32'd4;
    chk(pred_hit === exp_hit, req, "pred_hit", 32'(pred_hit), 32'(exp_hit));
    chk(next_fetch_addr === exp_next, req, "next_fetch_addr", next_fetch_addr, exp_next);
    if (exp_hit)
      chk(pred_target === exp_tgt, req, "pred_target", pred_target, exp_tgt);
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt, input bit taken);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = taken;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1, R3: empty after reset, sequential fall-through with wrap
  task automatic t_reset;
    do_reset();
    look(32'h0000_1000, 1'b0, '0, "R1");
    look(br_pc(5), 1'b0, '0, "R1");
    look(32'h0000_2000, 1'b0, '0, "R3");
    look(32'hFFFF_FFFC, 1'b0, '0, "R3");
  endtask

  // R2, R4, R9, R10: install, same-cycle collision, low-bit masking
  task automatic t_install;
    do_reset();
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_4003; upd_target = 32'h0000_9000; upd_taken = 1'b1;
    look(32'h0000_4000, 1'b0, '0, "R9");      // update not yet visible
    @(negedge clk);
    upd_valid = 1'b0;
    look(32'h0000_4000, 1'b1, 32'h0000_9000, "R4");
    look(32'h0000_4002, 1'b1, 32'h0000_9000, "R10");
    look(32'h0000_4004, 1'b0, '0, "R10");
    look(32'h0000_4001, 1'b1, 32'h0000_9000, "R2");
    upd(32'h0000_4000, 32'h0000_9000, 1'b1);  // same address again: no second copy
    look(32'h0000_4000, 1'b1, 32'h0000_9000, "R4");
  endtask

  // R5, R6, R8: full capacity, refresh keeps order, oldest evicted
  task automatic t_wrap;
    do_reset();
    upd(br_pc(0), 32'h0000_7000, 1'b1);
    upd(br_pc(0), br_tgt(0), 1'b1);           // refresh target
    look(br_pc(0), 1'b1, br_tgt(0), "R8");
    for (int i = 1; i < 64; i++) upd(br_pc(i), br_tgt(i), 1'b1);
    for (int i = 0; i < 64; i++) look(br_pc(i), 1'b1, br_tgt(i), "R5");
    upd(br_pc(64), br_tgt(64), 1'b1);
    look(br_pc(0), 1'b0, '0, "R6");
    look(br_pc(1), 1'b1, br_tgt(1), "R8");    // refresh did not move the pointer
    look(br_pc(64), 1'b1, br_tgt(64), "R6");
    upd(br_pc(65), br_tgt(65), 1'b1);
    look(br_pc(1), 1'b0, '0, "R6");
    look(br_pc(2), 1'b1, br_tgt(2), "R6");
    look(br_pc(63), 1'b1, br_tgt(63), "R6");
  endtask

  // R7, R9, R11: removal, collision with removal, ignored updates
  task automatic t_remove;
    do_reset();
    upd(br_pc(10), br_tgt(10), 1'b1);
    upd(br_pc(11), br_tgt(11), 1'b1);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = br_pc(10); upd_target = '0; upd_taken = 1'b0;
    look(br_pc(10), 1'b1, br_tgt(10), "R9");  // still old contents
    @(negedge clk);
    upd_valid = 1'b0;
    look(br_pc(10), 1'b0, '0, "R7");
    look(br_pc(11), 1'b1, br_tgt(11), "R7");
    upd(br_pc(20), br_tgt(20), 1'b0);         // not-taken miss
    look(br_pc(20), 1'b0, '0, "R11");
    look(br_pc(11), 1'b1, br_tgt(11), "R11");
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = br_pc(21); upd_target = br_tgt(21); upd_taken = 1'b1;
    @(negedge clk);
    look(br_pc(21), 1'b0, '0, "R11");
    upd(br_pc(11), '0, 1'b0);
    look(br_pc(11), 1'b0, '0, "R7");
  endtask

  initial begin
    t_reset();
    t_install();
    t_wrap();
    t_remove();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R1-R11 run: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule